// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block executes one atomic memory operation at a time against a plain synchronous memory port. A request selects a load-type or store-type operation, a 5-bit function code, an element width of 8, 16, 32 or 64 bits, a byte address aligned to that width, and two 64-bit register operands. The unit reads the one or two memory elements the function needs and computes the new element at the selected width. Where the function calls for it, the unit writes the result back with byte enables. Load-type operations return the prior element value, zero-extended to 64 bits. Store-type operations return zero.

Besides the usual fetch-and-op functions, the unit handles several functions that look at two neighbouring elements: a bounded increment and an equal-gated increment, which compare against the element above; a bounded decrement, which compares against the element below; and a twin store, which writes to both elements. The unit also has a compare-and-swap that writes only when the compare value differs from the element. A request with an unknown function code or a misaligned address is refused. It raises an illegal flag and touches no memory.

The memory is 64 bits wide and word-addressed, and it returns read data one cycle after a read request. Bytes are little-endian inside a word.

Top module: `amo_unit`

## Requirements
- R1: Width code 0, 1, 2 and 3 selects 8, 16, 32 and 64-bit elements (s = 1, 2, 4, 8 bytes). All arithmetic and comparisons are done at that width. Results wrap to that width. Returned values are zero above the width.
- R2: Load codes 0 (add), 1 (XOR), 2 (OR) and 3 (AND) combine the element at the address with operand A, write the result and return the prior element.
- R3: Load codes 4 (max unsigned), 5 (max signed), 6 (min unsigned) and 7 (min signed) write the chosen value of the element and operand A and return the prior element. Signedness uses the top bit of the width.
- R4: Load code 8 (swap) writes operand A and returns the prior element.
- R5: Load code 16 (compare-and-swap-not-equal) writes operand B only when the element differs from operand A. It always returns the prior element.
- R6: Load code 24 (increment bounded) reads the elements at the address and at the address plus s. When they differ it writes the first element plus one and returns the first element. Otherwise it writes nothing and returns a value with only the top bit of the width set.
- R7: Load code 25 (increment equal) follows the same rule as R6, but the update and the old-value return happen only when the two elements are equal.
- R8: Load code 28 (decrement bounded) reads the elements at the address minus s and at the address. When they differ it writes the element at the address minus one and returns the old element. Otherwise it writes nothing and returns only the top bit of the width.
- R9: Store codes 0 to 7 apply add, XOR, OR, AND, max unsigned, max signed, min unsigned and min signed, in that code order, with operand A into the element. They return zero.
- R10: Store code 24 (twin store) writes operand A to the element at the address and to the element at the address plus s, but only when those two elements are equal. It returns zero.
- R11: Any other function code, or an address not a multiple of s, completes with the illegal flag set and data zero, and makes no memory write.
- R12: Busy rises on the edge that accepts a request and stays high until the cycle of the one-cycle done pulse. Request valid is ignored while busy.
- R13: A memory write goes to word address = byte address / 8. Its byte enables cover exactly bytes (address mod 8) up to (address mod 8) + s - 1 of that word, and the other bytes of the word keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_store | input | 1 | 1 = store-type, 0 = load-type |
| req_fc | input | 5 | Function code |
| req_ew | input | 2 | Element width code |
| req_addr | input | ADDR_W | Byte address |
| req_opa | input | 64 | Operand A (value / compare value) |
| req_opb | input | 64 | Operand B (replacement for code 16) |
| busy | output | 1 | Operation in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Returned value, valid with rsp_done |
| rsp_illegal | output | 1 | Request refused, valid with rsp_done |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-3 | Word address |
| mem_be | output | 8 | Byte enables for writes |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read request |

## Verification
The bench goes after width wrap-around and signedness. An 8-bit add that carries out must not reach the next byte, and a signed max must see 0x80 as negative. A design that worked at 64 bits throughout would corrupt neighbouring bytes or choose the wrong operand. The neighbour-element functions are run on both the equal and the differing branch, including a decrement whose lower neighbour lies in the previous word and twin stores that span two words. A swapped compare polarity would show up as a wrong write, or as a missing top-bit return value. Misaligned and unknown requests, and a request pulsed while busy, are checked against the whole memory image to catch a stray write.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN   = 64;
  localparam int NBYTE  = XLEN / 8;
  localparam int OFF_W  = $clog2(NBYTE);
  localparam int FC_W   = 5;

  localparam logic [FC_W-1:0] FC_ADD  = 5'd0;
  localparam logic [FC_W-1:0] FC_XOR  = 5'd1;
  localparam logic [FC_W-1:0] FC_OR   = 5'd2;
  localparam logic [FC_W-1:0] FC_AND  = 5'd3;
  localparam logic [FC_W-1:0] FC_MAXU = 5'd4;
  localparam logic [FC_W-1:0] FC_MAXS = 5'd5;
  localparam logic [FC_W-1:0] FC_MINU = 5'd6;
  localparam logic [FC_W-1:0] FC_MINS = 5'd7;
  localparam logic [FC_W-1:0] FC_SWAP = 5'd8;
  localparam logic [FC_W-1:0] FC_CSNE = 5'd16;
  localparam logic [FC_W-1:0] FC_INCB = 5'd24;
  localparam logic [FC_W-1:0] FC_INCE = 5'd25;
  localparam logic [FC_W-1:0] FC_DECB = 5'd28;

  typedef struct packed {
    logic            wr;
    logic [XLEN-1:0] wval;
    logic [XLEN-1:0] ret;
  } amo_res_t;

  function automatic logic [XLEN-1:0] width_mask(input logic [1:0] ew);
    case (ew)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] top_bit(input logic [1:0] ew);
    case (ew)
      2'd0:    return 64'h0000_0000_0000_0080;
      2'd1:    return 64'h0000_0000_0000_8000;
      2'd2:    return 64'h0000_0000_8000_0000;
      default: return 64'h8000_0000_0000_0000;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sign_ext(input logic [XLEN-1:0] x,
                                               input logic [1:0] ew);
    case (ew)
      2'd0:    return {{56{x[7]}},  x[7:0]};
      2'd1:    return {{48{x[15]}}, x[15:0]};
      2'd2:    return {{32{x[31]}}, x[31:0]};
      default: return x;
    endcase
  endfunction

  function automatic logic [NBYTE-1:0] byte_mask(input logic [1:0] ew);
    case (ew)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic aligned(input logic [OFF_W-1:0] off,
                                   input logic [1:0] ew);
    case (ew)
      2'd0:    return 1'b1;
      2'd1:    return off[0] == 1'b0;
      2'd2:    return off[1:0] == 2'b00;
      default: return off == '0;
    endcase
  endfunction
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic            store,
  input  logic [FC_W-1:0] fc,
  input  logic [1:0]      ew,
  input  logic [OFF_W-1:0] off,
  output logic            legal,
  output logic            two_elem,
  output logic            below
);
  logic fn_ok;

  always_comb begin
    if (store) begin
      fn_ok    = (fc <= FC_MINS) || (fc == FC_INCB);
      two_elem = (fc == FC_INCB);
    end else begin
      fn_ok    = (fc <= FC_SWAP) || (fc == FC_CSNE) || (fc == FC_INCB) ||
                 (fc == FC_INCE) || (fc == FC_DECB);
      two_elem = (fc == FC_INCB) || (fc == FC_INCE) || (fc == FC_DECB);
    end
    below = !store && (fc == FC_DECB);
    legal = fn_ok && aligned(off, ew);
  end
endmodule

// File: rtl/amo_lane.sv
module amo_lane
  import amo_pkg::*;
(
  input  logic [1:0]       ew,
  input  logic [OFF_W-1:0] off,
  input  logic [XLEN-1:0]  rdata,
  input  logic [XLEN-1:0]  wval,
  output logic [XLEN-1:0]  elem,
  output logic [XLEN-1:0]  wdata,
  output logic [NBYTE-1:0] be
);
  logic [OFF_W+2:0] bit_sh;

  always_comb begin
    bit_sh = {off, 3'b000};
    elem   = (rdata >> bit_sh) & width_mask(ew);
    wdata  = (wval & width_mask(ew)) << bit_sh;
    be     = byte_mask(ew) << off;
  end
endmodule

// File: rtl/amo_compute.sv
module amo_compute
  import amo_pkg::*;
(
  input  logic            store,
  input  logic [FC_W-1:0] fc,
  input  logic [1:0]      ew,
  input  logic [XLEN-1:0] elem_a,
  input  logic [XLEN-1:0] elem_b,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output amo_res_t        res
);
  logic [XLEN-1:0] mk, a, b, x, y, nv;
  logic            wr, gated;
  logic signed [XLEN-1:0] sa, sx;

  always_comb begin
    mk = width_mask(ew);
    a  = elem_a & mk;
    b  = elem_b & mk;
    x  = opa & mk;
    y  = opb & mk;
    sa = signed'(sign_ext(a, ew));
    sx = signed'(sign_ext(x, ew));
    wr    = 1'b1;
    gated = 1'b0;
    nv    = '0;
    case (fc)
      FC_ADD:  nv = a + x;
      FC_XOR:  nv = a ^ x;
      FC_OR:   nv = a | x;
      FC_AND:  nv = a & x;
      FC_MAXU: nv = (a > x) ? a : x;
      FC_MAXS: nv = (sa > sx) ? a : x;
      FC_MINU: nv = (a < x) ? a : x;
      FC_MINS: nv = (sa < sx) ? a : x;
      FC_SWAP: nv = x;
      FC_CSNE: begin
        wr = (a != x);
        nv = y;
      end
      FC_INCB: begin
        if (store) begin
          wr = (a == b);
          nv = x;
        end else begin
          gated = 1'b1;
          wr    = (a != b);
          nv    = a + 64'd1;
        end
      end
      FC_INCE: begin
        gated = 1'b1;
        wr    = (a == b);
        nv    = a + 64'd1;
      end
      FC_DECB: begin
        gated = 1'b1;
        wr    = (a != b);
        nv    = a - 64'd1;
      end
      default: wr = 1'b0;
    endcase
    res.wr   = wr;
    res.wval = nv & mk;
    if (store)
      res.ret = '0;
    else if (gated && !wr)
      res.ret = top_bit(ew);
    else
      res.ret = a;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [4:0]        req_fc,
  input  logic [1:0]        req_ew,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_opa,
  input  logic [63:0]       req_opb,
  output logic              busy,
  output logic              rsp_done,
  output logic [63:0]       rsp_data,
  output logic              rsp_illegal,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int NLANE   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDA, ST_CAPA, ST_CAPB, ST_EXEC, ST_WRB, ST_DONE
  } state_e;

  state_e            state;
  logic              store_q, two_q, ill_q;
  logic [FC_W-1:0]   fc_q;
  logic [1:0]        ew_q;
  logic [ADDR_W-1:0] ea_q, eb_q;
  logic [XLEN-1:0]   opa_q, opb_q, elem_a_q, elem_b_q, ret_q;

  // named events for the checker
  logic              accept, rd_fire, wr_fire;
  logic              dec_legal, dec_two, dec_below;
  logic [ADDR_W-1:0] step, eb_next;
  amo_res_t          res;

  logic [OFF_W-1:0]  lane_off   [NLANE];
  logic [XLEN-1:0]   lane_elem  [NLANE];
  logic [XLEN-1:0]   lane_wdata [NLANE];
  logic [NBYTE-1:0]  lane_be    [NLANE];

  assign accept = req_valid && (state == ST_IDLE);

  amo_decode u_dec (
    .store    (req_store),
    .fc       (req_fc),
    .ew       (req_ew),
    .off      (req_addr[OFF_W-1:0]),
    .legal    (dec_legal),
    .two_elem (dec_two),
    .below    (dec_below)
  );

  assign step    = ADDR_W'(1) << req_ew;
  assign eb_next = dec_below ? (req_addr - step) : (req_addr + step);

  assign lane_off[0] = ea_q[OFF_W-1:0];
  assign lane_off[1] = eb_q[OFF_W-1:0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    amo_lane u_lane (
      .ew    (ew_q),
      .off   (lane_off[g]),
      .rdata (mem_rdata),
      .wval  (res.wval),
      .elem  (lane_elem[g]),
      .wdata (lane_wdata[g]),
      .be    (lane_be[g])
    );
  end

  amo_compute u_cmp (
    .store  (store_q),
    .fc     (fc_q),
    .ew     (ew_q),
    .elem_a (elem_a_q),
    .elem_b (elem_b_q),
    .opa    (opa_q),
    .opb    (opb_q),
    .res    (res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      store_q  <= 1'b0;
      two_q    <= 1'b0;
      ill_q    <= 1'b0;
      fc_q     <= '0;
      ew_q     <= '0;
      ea_q     <= '0;
      eb_q     <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      elem_a_q <= '0;
      elem_b_q <= '0;
      ret_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            store_q <= req_store;
            fc_q    <= req_fc;
            ew_q    <= req_ew;
            ea_q    <= req_addr;
            eb_q    <= eb_next;
            opa_q   <= req_opa;
            opb_q   <= req_opb;
            two_q   <= dec_two;
            ill_q   <= !dec_legal;
            ret_q   <= '0;
            state   <= dec_legal ? ST_RDA : ST_DONE;
          end
        end
        ST_RDA:  state <= ST_CAPA;
        ST_CAPA: begin
          elem_a_q <= lane_elem[0];
          elem_b_q <= '0;
          state    <= two_q ? ST_CAPB : ST_EXEC;
        end
        ST_CAPB: begin
          elem_b_q <= lane_elem[1];
          state    <= ST_EXEC;
        end
        ST_EXEC: begin
          ret_q <= res.ret;
          state <= (res.wr && store_q && two_q) ? ST_WRB : ST_DONE;
        end
        ST_WRB:  state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_fire = (state == ST_RDA) || ((state == ST_CAPA) && two_q);
  assign wr_fire = ((state == ST_EXEC) && res.wr) || (state == ST_WRB);

  always_comb begin
    mem_req   = rd_fire || wr_fire;
    mem_we    = wr_fire;
    mem_addr  = ea_q[ADDR_W-1:OFF_W];
    mem_be    = '0;
    mem_wdata = '0;
    if ((state == ST_CAPA) || (state == ST_WRB))
      mem_addr = eb_q[ADDR_W-1:OFF_W];
    if (state == ST_EXEC && res.wr) begin
      mem_be    = lane_be[0];
      mem_wdata = lane_wdata[0];
    end else if (state == ST_WRB) begin
      mem_be    = lane_be[1];
      mem_wdata = lane_wdata[1];
    end
  end

  assign busy        = (state != ST_IDLE);
  assign rsp_done    = (state == ST_DONE);
  assign rsp_data    = ill_q ? '0 : ret_q;
  assign rsp_illegal = rsp_done && ill_q;

  logic [WADDR_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rsp_done,
  input logic        rsp_illegal,
  input logic [63:0] rsp_data,
  input logic        mem_req,
  input logic        mem_we,
  input logic [7:0]  mem_be,
  input logic [1:0]  ew_q,
  input logic        store_q,
  input logic        accept
);
  logic [1:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_cnt <= '0;
    else if (accept)
      wr_cnt <= '0;
    else if (mem_we && wr_cnt != 2'd3)
      wr_cnt <= wr_cnt + 2'd1;
  end

  // R12
  mem_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R12
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && !busy));

  // R13
  be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == (1 << ew_q)));

  // R1
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ((rsp_data & ~width_mask(ew_q)) == 64'd0));

  // R9
  store_ret_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && store_q) |-> (rsp_data == 64'd0));

  // R11
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_illegal) |-> (wr_cnt == 2'd0));

  // R10
  at_most_two_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (wr_cnt <= 2'd2));
endmodule

bind amo_unit amo_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .rsp_done    (rsp_done),
  .rsp_illegal (rsp_illegal),
  .rsp_data    (rsp_data),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_be      (mem_be),
  .ew_q        (ew_q),
  .store_q     (store_q),
  .accept      (accept)
);

// File: tb/amo_unit_bench.sv
module amo_unit_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_store = 1'b0;
  logic [4:0]    req_fc = '0;
  logic [1:0]    req_ew = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_opa = '0;
  logic [63:0]   req_opb = '0;
  logic          busy, rsp_done, rsp_illegal;
  logic [63:0]   rsp_data;
  logic          mem_req, mem_we;
  logic [AW-4:0] mem_addr;
  logic [7:0]    mem_be;
  logic [63:0]   mem_wdata;
  logic [63:0]   mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  amo_unit #(.ADDR_W(AW)) u_amo_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_fc(req_fc), .req_ew(req_ew), .req_addr(req_addr),
    .req_opa(req_opa), .req_opb(req_opb), .busy(busy), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .rsp_illegal(rsp_illegal), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: 256 bytes, word index taken from low address bits
  logic [7:0] mb [256];
  logic [7:0] sb [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mb[i] <= 8'(i * 37 + 5);
      mem_rdata <= '0;
    end else if (mem_req) begin
      for (int k = 0; k < 8; k++) begin
        if (mem_we && mem_be[k])
          mb[{mem_addr[4:0], 3'(k)}] <= mem_wdata[8*k +: 8];
        if (!mem_we)
          mem_rdata[8*k +: 8] <= mb[{mem_addr[4:0], 3'(k)}];
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sb_rd(input int addr, input int s);
    logic [63:0] v = '0;
    for (int k = 0; k < s; k++) v[8*k +: 8] = sb[(addr + k) & 255];
    return v;
  endfunction

  task automatic sb_wr(input int addr, input int s, input logic [63:0] v);
    for (int k = 0; k < s; k++) sb[(addr + k) & 255] = v[8*k +: 8];
  endtask

  // place a value in both the expected image and the memory, byte by byte
  task automatic poke(input int addr, input int s, input logic [63:0] v);
    sb_wr(addr, s, v);
    for (int k = 0; k < s; k++)
      mb[(addr + k) & 255] = v[8*k +: 8];
  endtask

  // independent prediction of one operation
  task automatic predict(input bit st, input int fc, input int ew, input int addr,
                         input logic [63:0] x, input logic [63:0] y,
                         output bit ill, output logic [63:0] ret);
    int s = 1 << ew;
    int w = 8 * s;
    logic [63:0] mk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] tb = 64'd1 << (w - 1);
    logic [63:0] a, b, xm, ym, nv;
    bit ok, wr, gated;
    ok = st ? (fc < 8 || fc == 24)
            : (fc < 9 || fc == 16 || fc == 24 || fc == 25 || fc == 28);
    if (!ok || (addr % s) != 0) begin
      ill = 1; ret = '0; return;
    end
    ill = 0;
    a  = sb_rd(addr, s);
    b  = sb_rd((fc == 28) ? addr - s : addr + s, s);
    xm = x & mk;
    ym = y & mk;
    wr = 1; gated = 0; nv = '0;
    case (fc)
      0: nv = a + xm;
      1: nv = a ^ xm;
      2: nv = a | xm;
      3: nv = a & xm;
      4: nv = (a > xm) ? a : xm;
      5: nv = ((a ^ tb) > (xm ^ tb)) ? a : xm;
      6: nv = (a < xm) ? a : xm;
      7: nv = ((a ^ tb) < (xm ^ tb)) ? a : xm;
      8: nv = xm;
      16: begin wr = (a != xm); nv = ym; end
      24: if (st) begin wr = (a == b); nv = xm; end
          else begin gated = 1; wr = (a != b); nv = a + 1; end
      25: begin gated = 1; wr = (a == b); nv = a + 1; end
      default: begin gated = 1; wr = (a != b); nv = a - 1; end
    endcase
    nv &= mk;
    ret = st ? 64'd0 : ((gated && !wr) ? tb : a);
    if (wr) sb_wr(addr, s, nv);
    if (wr && st && fc == 24) sb_wr(addr + s, s, nv);
  endtask

  task automatic mem_image(input string tag);
    int diffs = 0;
    for (int i = 0; i < 256; i++) if (mb[i] !== sb[i]) diffs++;
    check({tag, " memory image diffs"}, 64'(diffs), 64'd0);
  endtask

  task automatic issue(input bit st, input int fc, input int ew, input int addr,
                       input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    req_valid = 1; req_store = st; req_fc = 5'(fc); req_ew = 2'(ew);
    req_addr = AW'(addr); req_opa = x; req_opb = y;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_op(input string tag, input bit eill,
                           input logic [63:0] eret);
    int n = 0;
    while (!rsp_done && n < 30) begin @(negedge clk); n++; end
    check({tag, " done seen"}, 64'(rsp_done), 64'd1);
    check({tag, " data"}, rsp_data, eret);
    check({tag, " illegal"}, 64'(rsp_illegal), 64'(eill));
    @(negedge clk);
    mem_image(tag);
  endtask

  task automatic do_op(input string tag, input bit st, input int fc,
                       input int ew, input int addr,
                       input logic [63:0] x, input logic [63:0] y);
    bit eill; logic [63:0] eret;
    predict(st, fc, ew, addr, x, y, eill, eret);
    issue(st, fc, ew, addr, x, y);
    finish_op(tag, eill, eret);
  endtask

  task automatic t_reset;
    check("R12 reset busy", 64'(busy), 0);
    check("R12 reset done", 64'(rsp_done), 0);
    check("R12 reset mem_req", 64'(mem_req), 0);
  endtask

  task automatic t_fetch_logic;
    poke(8'h10, 1, 64'hF0);
    do_op("R2 add8 wrap (R1)", 0, 0, 0, 8'h10, 64'h20, 0);
    poke(8'h12, 2, 64'h1234);
    do_op("R2 xor16", 0, 1, 1, 8'h12, 64'hFFFF_0F0F, 0);
    do_op("R2 or32", 0, 2, 2, 8'h14, 64'hFFFF_0000_8000_0001, 0);
    do_op("R2 and64", 0, 3, 3, 8'h18, 64'h0F0F_F0F0_AAAA_5555, 0);
    poke(8'h20, 8, '1);
    do_op("R1 add64 wrap", 0, 0, 3, 8'h20, 64'd2, 0);
  endtask

  task automatic t_minmax;
    poke(8'h28, 1, 64'h80);
    do_op("R3 maxs8", 0, 5, 0, 8'h28, 64'h01, 0);
    poke(8'h29, 1, 64'h80);
    do_op("R3 maxu8", 0, 4, 0, 8'h29, 64'h01, 0);
    poke(8'h2A, 2, 64'h7FFF);
    do_op("R3 mins16", 0, 7, 1, 8'h2A, 64'h8000, 0);
    poke(8'h2C, 4, 64'h8000_0000);
    do_op("R3 minu32", 0, 6, 2, 8'h2C, 64'h7FFF_FFFF, 0);
  endtask

  task automatic t_swap;
    do_op("R4 swap16", 0, 8, 1, 8'h30, 64'hDEAD_BEEF, 0);
    do_op("R4 swap64", 0, 8, 3, 8'h38, 64'h0123_4567_89AB_CDEF, 0);
  endtask

  task automatic t_csne;
    poke(8'h40, 4, 64'h5555_AAAA);
    do_op("R5 csne equal no write", 0, 16, 2, 8'h40, 64'h5555_AAAA, 64'h1111);
    do_op("R5 csne differ writes", 0, 16, 2, 8'h40, 64'h1, 64'h2222_3333);
  endtask

  task automatic t_inc;
    poke(8'h48, 2, 64'h0005); poke(8'h4A, 2, 64'h0009);
    do_op("R6 incb differ", 0, 24, 1, 8'h48, 0, 0);
    poke(8'h48, 2, 64'h0009);
    do_op("R6 incb equal top bit", 0, 24, 1, 8'h48, 0, 0);
    poke(8'h4E, 1, 64'h3C); poke(8'h4F, 1, 64'h3C);
    do_op("R7 ince equal", 0, 25, 0, 8'h4E, 0, 0);
    do_op("R7 ince differ top bit", 0, 25, 0, 8'h4E, 0, 0);
    poke(8'h50, 8, 64'h77); poke(8'h58, 8, 64'h77);
    do_op("R6 incb64 equal top bit", 0, 24, 3, 8'h50, 0, 0);
  endtask

  task automatic t_dec;
    poke(8'h60, 4, 64'h10); poke(8'h5C, 4, 64'h10);
    do_op("R8 decb equal top bit", 0, 28, 2, 8'h60, 0, 0);
    poke(8'h5C, 4, 64'h3);
    do_op("R8 decb prev word", 0, 28, 2, 8'h60, 0, 0);
    poke(8'h00, 1, 64'h00);
    do_op("R8 decb wrap below zero", 0, 28, 0, 8'h00, 0, 0);
  endtask

  task automatic t_store;
    for (int f = 0; f < 8; f++)
      do_op($sformatf("R9 store fn %0d", f), 1, f, f % 4, 8'h68 + 8 * (f % 3),
            64'h8765_4321_0FED_CBA9 + 64'(f), 0);
  endtask

  task automatic t_twin;
    poke(8'h86, 2, 64'hABCD); poke(8'h88, 2, 64'hABCD);
    do_op("R10 twin equal spans words", 1, 24, 1, 8'h86, 64'h1357, 0);
    poke(8'h90, 4, 64'h1); poke(8'h94, 4, 64'h2);
    do_op("R10 twin differ no write", 1, 24, 2, 8'h90, 64'hFFFF, 0);
  endtask

  task automatic t_illegal;
    do_op("R11 load code 9", 0, 9, 0, 8'hA0, 64'h55, 0);
    do_op("R11 store code 8", 1, 8, 3, 8'hA0, 64'h55, 0);
    do_op("R11 store code 16", 1, 16, 1, 8'hA0, 64'h55, 0);
    do_op("R11 misaligned 32", 0, 0, 2, 8'hA2, 64'h55, 0);
    do_op("R11 misaligned 16", 1, 1, 1, 8'hA1, 64'h55, 0);
  endtask

  task automatic t_busy_ignore;
    bit eill; logic [63:0] eret;
    int quiet = 0;
    predict(0, 0, 2, 8'hB0, 64'h10, 0, eill, eret);
    issue(0, 0, 2, 8'hB0, 64'h10, 0);
    check("R12 busy after accept", 64'(busy), 1);
    req_valid = 1; req_store = 1; req_fc = 5'd8 - 5'd8; req_ew = 2'd3;
    req_addr = AW'(8'hC0); req_opa = '1;
    @(negedge clk);
    req_valid = 0;
    finish_op("R12 request while busy ignored", eill, eret);
    for (int i = 0; i < 6; i++) begin
      if (rsp_done || busy) quiet++;
      @(negedge clk);
    end
    check("R12 no second operation", 64'(quiet), 0);
    mem_image("R12 after idle");
  endtask

  task automatic t_lanes;
    for (int o = 0; o < 8; o++)
      do_op($sformatf("R13 byte lane %0d", o), 0, 0, 0, 8'hC8 + o, 64'hFF, 0);
    do_op("R13 half lane 6", 1, 1, 1, 8'hD6, 64'hF00F, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) sb[i] = 8'(i * 37 + 5);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fetch_logic();
    t_minmax();
    t_swap();
    t_csne();
    t_inc();
    t_dec();
    t_store();
    t_twin();
    t_illegal();
    t_busy_ignore();
    t_lanes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule